// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside an 8-bit microcontroller core and decides when the core and its peripherals are clocked. Software writes a control word that holds two request bits: a light sleep, where only the CPU clock stops, and a deep sleep, where the oscillator is told to halt. The instruction that performs the write is the last one the CPU runs before its clock enable drops. While the core is in a low-power state, the block also drives the external bus strobes and the release of the low address/data port to the levels that state calls for.

There are three ways out. An enabled interrupt ends light sleep and hands off to the normal interrupt logic. A falling edge on any pin of the wake port ends either sleep state. A reset pin held high for enough cycles ends either state and resets the rest of the chip. A falling edge is captured without a clock, so it can restart a stopped oscillator. It then passes through a synchronizer. After a port wake, the block either requests the fixed wake vector or tells the core to resume at the next instruction, depending on the global interrupt enable. A wake flag records every exit from sleep and is cleared when the service routine acknowledges it.

Top module: `lpm_ctrl`

## Requirements
- R1: A control write (`ctl_wr`) in run state with `ctl_idl`=1 and `ctl_pd`=0 enters idle at that clock edge: `cpu_clk_en`=0, `per_clk_en`=1, `osc_stop`=0. A write with both bits 0 leaves the block running.
- R2: A control write with both `ctl_idl` and `ctl_pd` set enters power-down, not idle.
- R3: In power-down, `cpu_clk_en`=0, `per_clk_en`=0 and `osc_stop`=1, unless a wake edge is pending or `res_pin` is high.
- R4: In idle, a request with `irq_req[i]`, `irq_en[i]` and `irq_ea` all set returns the block to run at the next edge, with no vector request or resume pulse. A request without its enable, or with `irq_ea`=0, is ignored. Interrupts are ignored in power-down.
- R5: While `res_pin` stays high for `RST_HOLD` (24) consecutive edges, `core_rst` rises at the 24th edge. At the next edge the block enters run and the wake flag is cleared. A shorter pulse changes no state. `osc_stop` is low while `res_pin` is high.
- R6: A falling edge on any bit of `wake_n` during idle or power-down is registered as a run state at the third clock edge after it. In that same cycle, `wake_vec_req` is high for one cycle with `wake_vec_addr`=0x0023 if `irq_ea`=1. Otherwise `wake_resume` is high for one cycle. Falling edges in run state and rising edges have no effect.
- R7: `wake_flag` is set on every exit from idle or power-down other than reset. It is cleared only by `isr_ack` or reset, so it stays set when no service routine runs.
- R8: `ale_pin`/`psen_pin` follow `core_ale`/`core_psen` and `p0_hiz` follows `core_p0_hiz` in run. In idle both strobes are 1, and in power-down both are 0. In either sleep state, `p0_hiz` equals `ext_prog`.
- R9: In power-down, a falling edge on `wake_n` drops `osc_stop` at once, with no clock edge needed.
- R10: If an enabled interrupt and a synchronized port edge arrive in the same idle cycle, the interrupt exit wins: the block runs, the flag is set, and neither `wake_vec_req` nor `wake_resume` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| res_pin | input | 1 | External reset pin, active high |
| ctl_wr | input | 1 | Control write strobe from the core |
| ctl_idl | input | 1 | Idle request bit of the write |
| ctl_pd | input | 1 | Power-down request bit of the write |
| irq_req | input | IRQ_W | Pending interrupt sources |
| irq_en | input | IRQ_W | Per-source enables |
| irq_ea | input | 1 | Global interrupt enable |
| isr_ack | input | 1 | Service routine entry, clears the wake flag |
| wake_n | input | WAKE_W | Wake port pins, falling edge active |
| ext_prog | input | 1 | Program memory is external |
| core_ale | input | 1 | Address strobe from the core in run |
| core_psen | input | 1 | Program read strobe from the core in run |
| core_p0_hiz | input | 1 | Port-0 release from the core in run |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| osc_stop | output | 1 | Oscillator halt request |
| core_rst | output | 1 | Qualified reset to the rest of the chip |
| wake_vec_req | output | 1 | One-cycle request to jump to the wake vector |
| wake_vec_addr | output | 16 | Wake vector address, valid with the request |
| wake_resume | output | 1 | One-cycle request to resume at the next instruction |
| wake_flag | output | 1 | Set on wake, cleared by service routine |
| ale_pin | output | 1 | Address strobe pin level |
| psen_pin | output | 1 | Program read strobe pin level |
| p0_hiz | output | 1 | Port-0 released (floating) |

## Verification
Two sets of functions can fall in the same cycle. The first is the interrupt exit and the port-edge exit from idle. The bench drops a wake pin, then raises an enabled interrupt exactly two edges later, so both arrive when the synchronized edge pulse is live. It judges the result by a run state, a set flag and the absence of both the vector and resume pulses. The second is the two request bits in one control write, judged by the power-down pin levels and oscillator halt. A sweep over every wake pin, both sleep states and both enable settings checks the three-edge wake latency and the vector/resume choice.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN   = 2'd0,
        LPM_IDLE  = 2'd1,
        LPM_PDOWN = 2'd2
    } lpm_mode_e;

    typedef struct packed {
        logic ale;
        logic psen;
        logic p0_hiz;
    } lpm_pins_t;

    typedef struct packed {
        logic any;     // left a sleep state this cycle (not via reset)
        logic vec;     // port wake with vectoring
        logic resume;  // port wake without vectoring
    } lpm_exit_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc_stop;
    } lpm_clk_t;

    function automatic lpm_mode_e next_from_write(input logic idl, input logic pd);
        if (pd)       return LPM_PDOWN;
        else if (idl) return LPM_IDLE;
        else          return LPM_RUN;
    endfunction

    function automatic lpm_pins_t pins_for(input lpm_mode_e m, input lpm_pins_t core_p,
                                           input logic ext_prog);
        lpm_pins_t p;
        case (m)
            LPM_IDLE:  p = '{ale: 1'b1, psen: 1'b1, p0_hiz: ext_prog};
            LPM_PDOWN: p = '{ale: 1'b0, psen: 1'b0, p0_hiz: ext_prog};
            default:   p = core_p;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lpm_wake_capture.sv
module lpm_wake_capture #(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAKE_W-1:0] wake_n,
    output logic              pend,
    output logic              pulse
);
    logic [WAKE_W-1:0] tog;
    logic [WAKE_W-1:0] s1, s2, s3;

    // One clockless toggle per pin: each falling edge flips it.
    for (genvar i = 0; i < WAKE_W; i++) begin : g_pin
        logic t;
        always_ff @(negedge wake_n[i] or posedge rst) begin
            if (rst) t <= 1'b0;
            else     t <= ~t;
        end
        assign tog[i] = t;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= tog;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // pend: an edge not yet consumed (valid without clock);
    // pulse: synchronized edge, one cycle
    assign pend  = |(tog ^ s3);
    assign pulse = |(s2 ^ s3);

endmodule

// File: rtl/lpm_reset_qual.sv
module lpm_reset_qual #(
    parameter int RST_HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic res_pin,
    output logic core_rst
);
    localparam int CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(RST_HOLD);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !res_pin) cnt <= '0;
        else if (cnt != HOLD_V) cnt <= cnt + 1'b1;
    end

    assign core_rst = (cnt == HOLD_V);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_rst,
    input  logic             res_pin,
    input  logic             ctl_wr,
    input  logic             ctl_idl,
    input  logic             ctl_pd,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             irq_ea,
    input  logic             isr_ack,
    input  logic             edge_pend,
    input  logic             edge_pulse,
    output lpm_mode_e        mode,
    output lpm_clk_t         clk_en,
    output lpm_exit_t        exit_q,
    output logic             wake_flag
);
    logic      irq_live;
    lpm_exit_t exit_d;
    lpm_mode_e mode_d;

    assign irq_live = irq_ea && (|(irq_req & irq_en));

    always_comb begin
        exit_d = '0;
        mode_d = mode;
        case (mode)
            LPM_RUN: begin
                if (ctl_wr) mode_d = next_from_write(ctl_idl, ctl_pd);
            end
            LPM_IDLE: begin
                if (irq_live) begin
                    exit_d.any = 1'b1;
                    mode_d     = LPM_RUN;
                end else if (edge_pulse) begin
                    exit_d.any    = 1'b1;
                    exit_d.vec    = irq_ea;
                    exit_d.resume = !irq_ea;
                    mode_d        = LPM_RUN;
                end
            end
            LPM_PDOWN: begin
                if (edge_pulse) begin
                    exit_d.any    = 1'b1;
                    exit_d.vec    = irq_ea;
                    exit_d.resume = !irq_ea;
                    mode_d        = LPM_RUN;
                end
            end
            default: mode_d = LPM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || core_rst) begin
            mode      <= LPM_RUN;
            exit_q    <= '0;
            wake_flag <= 1'b0;
        end else begin
            mode   <= mode_d;
            exit_q <= exit_d;
            if (exit_d.any)   wake_flag <= 1'b1;
            else if (isr_ack) wake_flag <= 1'b0;
        end
    end

    always_comb begin
        clk_en.cpu      = (mode == LPM_RUN);
        clk_en.per      = (mode != LPM_PDOWN);
        clk_en.osc_stop = (mode == LPM_PDOWN) && !res_pin && !edge_pend;
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int          WAKE_W   = 8,
    parameter int          IRQ_W    = 5,
    parameter int          RST_HOLD = 24,
    parameter logic [15:0] VEC_ADDR = 16'h0023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_pin,
    input  logic              ctl_wr,
    input  logic              ctl_idl,
    input  logic              ctl_pd,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic              irq_ea,
    input  logic              isr_ack,
    input  logic [WAKE_W-1:0] wake_n,
    input  logic              ext_prog,
    input  logic              core_ale,
    input  logic              core_psen,
    input  logic              core_p0_hiz,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_stop,
    output logic              core_rst,
    output logic              wake_vec_req,
    output logic [15:0]       wake_vec_addr,
    output logic              wake_resume,
    output logic              wake_flag,
    output logic              ale_pin,
    output logic              psen_pin,
    output logic              p0_hiz
);
    logic      edge_pend, edge_pulse;
    lpm_mode_e mode;
    lpm_clk_t  clk_en;
    lpm_exit_t exit_q;
    lpm_pins_t core_p, pin_q;

    lpm_wake_capture #(.WAKE_W(WAKE_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .wake_n(wake_n),
        .pend  (edge_pend),
        .pulse (edge_pulse)
    );

    lpm_reset_qual #(.RST_HOLD(RST_HOLD)) u_rq (
        .clk     (clk),
        .rst     (rst),
        .res_pin (res_pin),
        .core_rst(core_rst)
    );

    lpm_mode_fsm #(.IRQ_W(IRQ_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .core_rst  (core_rst),
        .res_pin   (res_pin),
        .ctl_wr    (ctl_wr),
        .ctl_idl   (ctl_idl),
        .ctl_pd    (ctl_pd),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .irq_ea    (irq_ea),
        .isr_ack   (isr_ack),
        .edge_pend (edge_pend),
        .edge_pulse(edge_pulse),
        .mode      (mode),
        .clk_en    (clk_en),
        .exit_q    (exit_q),
        .wake_flag (wake_flag)
    );

    assign core_p = '{ale: core_ale, psen: core_psen, p0_hiz: core_p0_hiz};
    assign pin_q  = pins_for(mode, core_p, ext_prog);

    assign cpu_clk_en    = clk_en.cpu;
    assign per_clk_en    = clk_en.per;
    assign osc_stop      = clk_en.osc_stop;
    assign wake_vec_req  = exit_q.vec;
    assign wake_vec_addr = exit_q.vec ? VEC_ADDR : 16'h0000;
    assign wake_resume   = exit_q.resume;
    assign ale_pin       = pin_q.ale;
    assign psen_pin      = pin_q.psen;
    assign p0_hiz        = pin_q.p0_hiz;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ctl_wr,
    input logic ctl_idl,
    input logic ctl_pd,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_stop,
    input logic core_rst,
    input logic wake_vec_req,
    input logic wake_resume,
    input logic wake_flag,
    input logic ale_pin,
    input logic psen_pin
);
    AST_WRITE_HALTS_CPU: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && (ctl_idl || ctl_pd) && cpu_clk_en && !core_rst) |=> !cpu_clk_en); // R1

    AST_OSC_ONLY_DEEP: assert property (@(posedge clk) disable iff (rst)
        osc_stop |-> (!per_clk_en && !cpu_clk_en)); // R3

    AST_RESET_RUNS: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> (cpu_clk_en && !wake_flag)); // R5

    AST_VEC_XOR_RESUME: assert property (@(posedge clk) disable iff (rst)
        wake_vec_req |-> !wake_resume); // R6

    AST_EXIT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wake_vec_req || wake_resume) |-> (wake_flag && cpu_clk_en)); // R7

    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && per_clk_en) |-> (ale_pin && psen_pin)); // R8

    AST_DEEP_STROBES: assert property (@(posedge clk) disable iff (rst)
        !per_clk_en |-> (!ale_pin && !psen_pin)); // R8

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_idl     (ctl_idl),
    .ctl_pd      (ctl_pd),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_stop    (osc_stop),
    .core_rst    (core_rst),
    .wake_vec_req(wake_vec_req),
    .wake_resume (wake_resume),
    .wake_flag   (wake_flag),
    .ale_pin     (ale_pin),
    .psen_pin    (psen_pin)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
    localparam int WAKE_W = 8;
    localparam int IRQ_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic res_pin = 1'b0, ctl_wr = 1'b0, ctl_idl = 1'b0, ctl_pd = 1'b0;
    logic [IRQ_W-1:0] irq_req = '0, irq_en = '0;
    logic irq_ea = 1'b0, isr_ack = 1'b0;
    logic [WAKE_W-1:0] wake_n = '1;
    logic ext_prog = 1'b0, core_ale = 1'b0, core_psen = 1'b1, core_p0_hiz = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_stop, core_rst;
    logic wake_vec_req, wake_resume, wake_flag, ale_pin, psen_pin, p0_hiz;
    logic [15:0] wake_vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpm_ctrl u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic idl, input logic pd);
        ctl_wr = 1'b1; ctl_idl = idl; ctl_pd = pd;
        step(1);
        ctl_wr = 1'b0; ctl_idl = 1'b0; ctl_pd = 1'b0;
    endtask

    // expected state as {cpu, per, osc, ale, psen}
    task automatic expect_state(input string tag, input int m);
        logic [4:0] e;
        case (m)
            1: e = 5'b01011;
            2: e = 5'b00100;
            default: e = {1'b1, 1'b1, 1'b0, core_ale, core_psen};
        endcase
        check(tag, {cpu_clk_en, per_clk_en, osc_stop, ale_pin, psen_pin}, e);
    endtask

    task automatic clear_flag();
        isr_ack = 1'b1; step(1); isr_ack = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // reset state
        expect_state("R8 reset run pass-through", 0);
        check("R7 reset flag", {wake_flag, wake_vec_req, wake_resume}, 3'b000);
        check("R8 run p0", p0_hiz, core_p0_hiz);

        // R1 write with no bits stays running
        write_ctl(1'b0, 1'b0);
        expect_state("R1 null write", 0);

        // R1/R4 idle entry and interrupt exits
        write_ctl(1'b1, 1'b0);
        expect_state("R1 idle entry", 1);
        irq_req = 5'b00100; irq_en = 5'b00010; irq_ea = 1'b1;
        step(2);
        expect_state("R4 unenabled irq ignored", 1);
        irq_en = 5'b00100; irq_ea = 1'b0;
        step(2);
        expect_state("R4 irq with ea=0 ignored", 1);
        irq_ea = 1'b1;
        step(1);
        irq_req = '0;
        expect_state("R4 enabled irq wakes", 0);
        check("R4 no port pulse", {wake_vec_req, wake_resume}, 2'b00);
        check("R7 flag after irq wake", wake_flag, 1'b1);
        clear_flag();
        check("R7 isr_ack clears", wake_flag, 1'b0);

        // R2 both bits -> power-down; R4 irq ignored there
        write_ctl(1'b1, 1'b1);
        expect_state("R2 both bits pd", 2);
        irq_req = 5'b00100;
        step(3);
        expect_state("R4 irq ignored in pd", 2);
        irq_req = '0;

        // R5 short reset pulse: no effect, osc released while held
        res_pin = 1'b1;
        step(10);
        check("R5 osc released by pin", osc_stop, 1'b0);
        check("R5 short no core_rst", core_rst, 1'b0);
        res_pin = 1'b0;
        step(2);
        expect_state("R5 short pulse ignored", 2);
        // R5 long reset pulse
        res_pin = 1'b1;
        step(23);
        check("R5 core_rst not yet", core_rst, 1'b0);
        step(1);
        check("R5 core_rst after hold", core_rst, 1'b1);
        step(1);
        expect_state("R5 reset exits pd", 0);
        res_pin = 1'b0;
        step(1);
        check("R5 core_rst released", core_rst, 1'b0);

        // R6/R7/R8/R9 sweep: pins x modes x enable
        for (int md = 1; md <= 2; md++) begin
            for (int ea = 0; ea < 2; ea++) begin
                for (int b = 0; b < WAKE_W; b++) begin
                    irq_ea = ea[0];
                    ext_prog = b[0];
                    write_ctl(md == 1, md == 2);
                    expect_state("R1 sweep entry", md);
                    check("R8 p0 in sleep", p0_hiz, ext_prog);
                    wake_n[b] = 1'b0;
                    #1;
                    if (md == 2) check("R9 osc released by edge", osc_stop, 1'b0);
                    step(2);
                    check("R6 asleep after two edges", cpu_clk_en, 1'b0);
                    step(1);
                    check("R6 awake at third edge", cpu_clk_en, 1'b1);
                    check("R6 vec/resume choice", {wake_vec_req, wake_resume},
                          ea ? 2'b10 : 2'b01);
                    check("R6 vector address", wake_vec_addr, ea ? 16'h0023 : 16'h0000);
                    check("R7 flag set", wake_flag, 1'b1);
                    wake_n[b] = 1'b1;
                    step(1);
                    check("R6 one-cycle pulse", {wake_vec_req, wake_resume}, 2'b00);
                    step(3);
                    check("R6 rising edge harmless", cpu_clk_en, 1'b1);
                    check("R7 flag holds", wake_flag, 1'b1);
                    clear_flag();
                    check("R7 cleared by ack", wake_flag, 1'b0);
                end
            end
        end

        // R6 falling edge in run is ignored
        wake_n[3] = 1'b0;
        step(4);
        wake_n[3] = 1'b1;
        check("R6 run edge ignored", {cpu_clk_en, wake_flag, wake_vec_req, wake_resume}, 4'b1000);

        // R8 run pass-through with other core values
        core_ale = 1'b1; core_psen = 1'b0; core_p0_hiz = 1'b1;
        #1;
        check("R8 run pins follow core", {ale_pin, psen_pin, p0_hiz}, 3'b101);

        // R10 coincident interrupt and port edge in idle
        irq_ea = 1'b1; irq_en = 5'b00001;
        write_ctl(1'b1, 1'b0);
        wake_n[5] = 1'b0;
        step(2);
        irq_req = 5'b00001;
        step(1);
        irq_req = '0;
        check("R10 coincident wakes", cpu_clk_en, 1'b1);
        check("R10 interrupt wins", {wake_vec_req, wake_resume}, 2'b00);
        check("R10 flag set", wake_flag, 1'b1);
        wake_n[5] = 1'b1;
        step(2);
        check("R10 no late pulse", {wake_vec_req, wake_resume}, 2'b00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule